// File: doc/BRIEF.md
# Reloadable 16-bit Timer and Event Counter

This block is a 16-bit up-counter that a processor reaches through an 8-bit register port. It has three addressable bytes: the low count byte, the high count byte and a control byte. The control byte picks one of three counting sources. In timer mode the counter advances on a strobe at one quarter of the system clock. In event mode it advances on a chosen edge of an external input. In pulse-width mode it counts the quarter-rate strobe during the time between a start edge and a stop edge on that input.

Writes to the count bytes set a 16-bit reload value. While the counter is stopped, a reload write also loads the count directly. While it is running, the new value waits until the next rollover. When the counter rolls over from FFFFh it reloads from the reload value and raises a one-cycle interrupt request. A single low-byte buffer makes 16-bit accesses atomic. A low-byte write only fills the buffer, and the following high-byte write commits both bytes at once. A high-byte read copies the live low byte into the buffer, and a later low-byte read returns that copy.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control byte reads 00h, both count bytes read 00h and `ovf_irq` is low.
- R2: The control byte (address 2) holds the mode in bits [7:6], enable in bit 4 and edge-select in bit 3. The mode encodings are 00 idle, 01 event, 10 timer and 11 pulse-width. Bits 5 and 2..0 always read as 0, so writing FFh reads back D8h.
- R3: In timer mode with enable set, the counter advances once every 4 system clocks. A window of 400 clocks adds exactly 100.
- R4: In event mode with enable set, edge-select 0 counts rising edges of `ext_in` and edge-select 1 counts falling edges. Edges of the other polarity have no effect.
- R5: In pulse-width mode with enable set and edge-select 1, the counter advances on the quarter-rate strobe from a rising edge of `ext_in` until the next falling edge. With edge-select 0 it counts from a falling edge until the next rising edge. A 40-clock pulse gives a count of 10, and the count holds after the stop edge.
- R6: The count does not change in idle mode, or while enable is 0 in any mode, unless a count write loads it.
- R7: A write to the low count byte (address 0) changes only the buffer, and the count stays the same. A write to the high count byte (address 1) updates both bytes together, taking the low byte from the buffer.
- R8: A read of the high count byte returns the live high byte and copies the live low byte into the buffer. A later read of the low byte returns that copy, even after the count has moved on.
- R9: While enable is 0, a count write loads the counter at once. While enable is 1, it only updates the reload value, and the counter keeps counting.
- R10: An advance from FFFFh loads the counter with the reload value and pulses `ovf_irq` high for exactly one clock. A reload value of 0000h restarts the count at 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Byte select: 0 low count, 1 high count, 2 control |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the clock after `bus_rd` |
| ext_in | input | 1 | External event or pulse input, asynchronous |
| ovf_irq | output | 1 | One-clock overflow interrupt request |

## Verification
The assertions assume that each bus access is a single-clock strobe and that `bus_wr` and `bus_rd` are never high in the same cycle. The one-clock interrupt property also assumes that `ext_in` stays at each level for at least one clock, so that two advances are never on back-to-back cycles. The bench drives every access through tasks that raise one strobe for exactly one clock. It holds `ext_in` at each level for at least four clocks. Before it enables counting, it always writes the reload value, because the reload value is undefined after reset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_EN_BIT  = 4;
  localparam int CTRL_SEL_BIT = 3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + 1'b1;
  end
endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise =  shreg[STAGES-1] & ~shreg[STAGES];
  assign fall = ~shreg[STAGES-1] &  shreg[STAGES];
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr_reload,
  input  logic         load_now,
  input  logic [W-1:0] reload_in,
  output logic [W-1:0] count,
  output logic [W-1:0] reload,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (wr_reload) reload <= reload_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (load_now) begin
        count <= reload_in;
      end else if (inc) begin
        if (count == MAXV) begin
          count <= reload;
          ovf   <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              ext_in,
  output logic              ovf_irq
);
  localparam int W = 2 * BYTE_W;

  tmr_mode_e         mode_q;
  logic              en_q;
  logic              sel_q;
  logic [BYTE_W-1:0] lo_buf;
  logic              gate_q;
  logic              tick, rise, fall, inc;
  logic [W-1:0]      cnt_q, reload_q;
  logic              wr_lo, wr_hi, wr_ctrl, rd_hi;
  logic              start_edge, stop_edge, event_edge;

  assign wr_lo   = bus_wr && (bus_addr == ADDR_LO);
  assign wr_hi   = bus_wr && (bus_addr == ADDR_HI);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_hi   = bus_rd && (bus_addr == ADDR_HI);

  tmr_prescale #(.DIV(CLK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_in), .rise(rise), .fall(fall)
  );

  // edge-select meaning differs per mode
  assign event_edge = sel_q ? fall : rise;
  assign start_edge = sel_q ? rise : fall;
  assign stop_edge  = sel_q ? fall : rise;

  always_ff @(posedge clk) begin
    if (rst || !en_q || (mode_q != MODE_PULSE)) gate_q <= 1'b0;
    else if (start_edge) gate_q <= 1'b1;
    else if (stop_edge) gate_q <= 1'b0;
  end

  always_comb begin
    inc = 1'b0;
    if (en_q) begin
      unique case (mode_q)
        MODE_EVENT: inc = event_edge;
        MODE_TIMER: inc = tick;
        MODE_PULSE: inc = gate_q & tick;
        default:    inc = 1'b0;
      endcase
    end
  end

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .inc(inc),
    .wr_reload(wr_hi), .load_now(wr_hi && !en_q),
    .reload_in({bus_wdata, lo_buf}),
    .count(cnt_q), .reload(reload_q), .ovf(ovf_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= tmr_mode_e'(bus_wdata[BYTE_W-1 -: 2]);
      en_q   <= bus_wdata[CTRL_EN_BIT];
      sel_q  <= bus_wdata[CTRL_SEL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lo_buf <= '0;
    else if (wr_lo) lo_buf <= bus_wdata;
    else if (rd_hi) lo_buf <= cnt_q[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        ADDR_LO: bus_rdata <= lo_buf;
        ADDR_HI: bus_rdata <= cnt_q[W-1:BYTE_W];
        ADDR_CTRL: begin
          bus_rdata[BYTE_W-1 -: 2]  <= mode_q;
          bus_rdata[CTRL_EN_BIT]  <= en_q;
          bus_rdata[CTRL_SEL_BIT] <= sel_q;
        end
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic        ovf_irq,
  input logic [1:0]  mode,
  input logic        en,
  input logic [15:0] cnt,
  input logic [15:0] reload
);
  logic hi_write;
  assign hi_write = bus_wr && (bus_addr == 2'd1);

  assert_ctrl_zero_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd2) |=> ((bus_rdata & 8'h27) == 8'h00));

  // R6: stopped counter holds unless loaded by a write
  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && !hi_write) |=> $stable(cnt));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !hi_write) |=> $stable(cnt));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |=> !ovf_irq);

  assert_reload_on_ovf_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_irq) |-> (cnt == $past(reload)));

  assert_ovf_from_max_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_irq) |-> ($past(cnt) == 16'hFFFF));
endmodule

bind evt_timer16 tmr_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ovf_irq(ovf_irq),
  .mode(mode_q), .en(en_q), .cnt(cnt_q), .reload(reload_q)
);

// File: tb/sim_evt_timer16.sv
module sim_evt_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0;
  logic       ovf_irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int irq_long = 0;
  logic irq_prev = 1'b0;

  always #5 clk = ~clk;

  evt_timer16 u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .ovf_irq(ovf_irq)
  );

  always @(negedge clk) begin
    if (ovf_irq) irq_cnt++;
    if (ovf_irq && irq_prev) irq_long++;
    irq_prev = ovf_irq;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd1, h);
    rd(2'd0, l);
    v = {h, l};
  endtask

  task automatic set16(input logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1; repeat (4) @(negedge clk);
      ext_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic wait_irq;
    for (int i = 0; i < 200 && !ovf_irq; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd2, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R1 high", d, 8'h00);
    rd(2'd0, d); chk("R1 low", d, 8'h00);
    chk("R1 irq", ovf_irq, 0);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 ctrl ff", d, 8'hD8);
    wr(2'd2, 8'h58); rd(2'd2, d); chk("R2 ctrl 58", d, 8'h58);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    set16(16'h0000);
    wr(2'd2, 8'h90);
    repeat (399) @(negedge clk);
    wr(2'd2, 8'h80);
    rd16(v); chk("R3 timer 400 clocks", v, 16'h0064);
  endtask

  task automatic t_hold;
    logic [15:0] v;
    wr(2'd2, 8'h10); repeat (40) @(negedge clk); pulse(2);
    rd16(v); chk("R6 idle mode", v, 16'h0064);
    wr(2'd2, 8'h80); repeat (40) @(negedge clk);
    rd16(v); chk("R6 timer disabled", v, 16'h0064);
    wr(2'd2, 8'h40); pulse(3);
    rd16(v); chk("R6 event disabled", v, 16'h0064);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_event;
    logic [15:0] v;
    set16(16'h0000);
    wr(2'd2, 8'h50); pulse(5);
    rd16(v); chk("R4 rising edges", v, 16'h0005);
    wr(2'd2, 8'h00); set16(16'h0000);
    wr(2'd2, 8'h58);
    ext_in = 1'b1; repeat (6) @(negedge clk);
    rd16(v); chk("R4 rise ignored on falling select", v, 16'h0000);
    ext_in = 1'b0; repeat (6) @(negedge clk);
    rd16(v); chk("R4 falling edge", v, 16'h0001);
    pulse(4);
    rd16(v); chk("R4 falling edges", v, 16'h0005);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_pulse;
    logic [15:0] v;
    set16(16'h0000);
    ext_in = 1'b0; repeat (6) @(negedge clk);
    wr(2'd2, 8'hD8);
    ext_in = 1'b1; repeat (40) @(negedge clk);
    ext_in = 1'b0; repeat (10) @(negedge clk);
    rd16(v); chk("R5 high pulse", v, 16'h000A);
    repeat (40) @(negedge clk);
    rd16(v); chk("R5 held after stop", v, 16'h000A);
    wr(2'd2, 8'h00); set16(16'h0000);
    ext_in = 1'b1; repeat (6) @(negedge clk);
    wr(2'd2, 8'hD0);
    repeat (20) @(negedge clk);
    rd16(v); chk("R5 level high no start", v, 16'h0000);
    ext_in = 1'b0; repeat (40) @(negedge clk);
    ext_in = 1'b1; repeat (10) @(negedge clk);
    rd16(v); chk("R5 low pulse", v, 16'h000A);
    wr(2'd2, 8'h00);
    ext_in = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic t_buffer;
    logic [15:0] v;
    logic [7:0] d;
    set16(16'h0000);
    wr(2'd0, 8'h34);
    rd(2'd1, d); chk("R7 low write no effect high", d, 8'h00);
    rd(2'd0, d); chk("R7 low write no effect low", d, 8'h00);
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    rd16(v); chk("R7 committed", v, 16'h1234);
    set16(16'h00FE);
    wr(2'd2, 8'h50);
    rd(2'd1, d); chk("R8 high read", d, 8'h00);
    pulse(3);
    rd(2'd0, d); chk("R8 low returns latched", d, 8'hFE);
    rd16(v); chk("R8 fresh pair", v, 16'h0101);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_reload;
    logic [15:0] v;
    logic [7:0] d;
    irq_cnt = 0; irq_long = 0;
    set16(16'hFFFC);
    rd16(v); chk("R9 direct load disabled", v, 16'hFFFC);
    chk("R10 no irq on load", irq_cnt, 0);
    wr(2'd2, 8'h90);
    set16(16'h0010);
    rd(2'd1, d); chk("R9 enabled write deferred", d, 8'hFF);
    wait_irq;
    wr(2'd2, 8'h00);
    rd16(v); chk("R10 reload value", v, 16'h0010);
    chk("R10 one irq", irq_cnt, 1);
    set16(16'hFFFE);
    wr(2'd2, 8'h90);
    set16(16'h0000);
    wait_irq;
    wr(2'd2, 8'h00);
    rd16(v); chk("R10 zero reload", v, 16'h0000);
    chk("R10 irq count", irq_cnt, 2);
    chk("R10 irq single cycle", irq_long, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_ctrl;
    t_timer;
    t_hold;
    t_event;
    t_pulse;
    t_buffer;
    t_reload;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule